// File: doc/BRIEF.md
# Scrambled Differential-Phase Barker Spreader

This block is the transmit baseband path for the two low-rate direct-sequence modes. Payload bits arrive one at a time over a valid/ready handshake. Each accepted bit first passes through a self-synchronizing scrambler. The scrambler keeps its seven most recent output bits, and a tap mask selects which of them feed back. The scrambled bits are then turned into a carried phase. In the one-bit mode each bit moves the phase by zero or a half turn. In the two-bit mode the bits are paired, and each pair moves the phase by a quarter-turn step.

Every finished symbol is spread over eleven consecutive clock cycles by a fixed Barker chip pattern. The block emits one I chip bit and one Q chip bit per cycle. A frame-start pulse prepares the block for a new frame. It loads one of two scrambler seeds, selected by a short/long preamble control, and returns the carried phase to zero. A rotation-reverse control flips the direction of quarter-turn steps.

Top module: `dsss_barker_mod`

## Requirements
- R1: After reset, `chipValid` is 0 and `bitReady` is 1.
- R2: For each accepted bit d, the scrambled bit is s = d XOR (XOR of `state[k]` for every k with `tapMask[k]` = 1). Here `state[k]` is the scrambled bit produced k+1 bits earlier. Then s is shifted into `state[0]`.
- R3: A cycle with `frameStart` = 1 has the following effects. `bitReady` is 0 and no bit is taken. The scrambler state is loaded with `seedShort` when `preambleShort` = 1, else with `seedLong`. The phase returns to 0°. A half-collected bit pair is dropped. Any symbol being spread stops, so `chipValid` is 0 in the next cycle.
- R4: With `rateSel` = 0, every scrambled bit is one symbol. A 1 adds 180° to the phase and a 0 leaves it unchanged, so `chipI` equals `chipQ`.
- R5: With `rateSel` = 1, two scrambled bits form one symbol, and the first one received is d0. The pair (d0,d1) sets the phase step: 00 gives 0°, 01 gives +90°, 11 gives +180°, 10 gives −90°. The step is added to the previous symbol's phase.
- R6: With `rotReverse` = 1 at the end of a symbol, the quarter-turn step is negated. A +90° step becomes −90° and a −90° step becomes +90°. Steps of 0° and 180° are unchanged.
- R7: A chip value of 0 stands for +1 and 1 stands for −1. The unspread symbol bits (I,Q) are (0,0) at 0°, (1,0) at 90°, (1,1) at 180° and (0,1) at 270°.
- R8: A symbol is output over 11 consecutive cycles with `chipValid` = 1. The first chip appears in the cycle after the symbol's last bit is accepted. Chip k (k = 0..10) equals the symbol bit XOR 1 for k in {1,4,8,9,10}, and equals the symbol bit otherwise. The same rule applies on I and on Q.
- R9: While chips are being output, `bitReady` is 0. It returns to 1 in the cycle after chip 10. A bit is taken only in a cycle with `bitValid` and `bitReady` both 1.
- R10: With `rateSel` = 1, accepting the first bit of a pair produces no chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one chip per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start of frame: load seed, zero phase |
| preambleShort | input | 1 | Seed select: 1 chooses the short-preamble seed |
| seedLong | input | 7 | Scrambler seed for long-preamble frames |
| seedShort | input | 7 | Scrambler seed for short-preamble frames |
| tapMask | input | 7 | Feedback enable per delayed scrambler bit |
| rateSel | input | 1 | 0: one bit per symbol, 1: two bits per symbol |
| rotReverse | input | 1 | Reverses the quarter-turn rotation sense |
| bitValid | input | 1 | Input bit present |
| bitData | input | 1 | Input bit |
| bitReady | output | 1 | Block can take a bit this cycle |
| chipValid | output | 1 | Chip outputs are valid |
| chipI | output | 1 | In-phase chip (1 means −1) |
| chipQ | output | 1 | Quadrature chip (1 means −1) |

## Verification
The embedded properties assume that `rateSel` changes only together with a `frameStart` pulse, and only while no symbol is being spread. In particular, the equal-I/Q property holds only if no odd phase left over from pair mode carries into one-bit mode. The stimulus follows this assumption: it picks rate, taps, seeds and rotation sense at random once per frame and applies them only in the same cycle as the frame-start pulse. It keeps `rotReverse` constant within a frame. Directed cases cover a frame that ends on half a pair and a frame start that cuts a symbol short.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int BARKER_LEN = 11;
  localparam int CHIP_IDX_W = $clog2(BARKER_LEN);
  // bit k set: chip k of the spreading word is -1 (inverts the symbol bit)
  localparam logic [BARKER_LEN-1:0] BARKER_INV = 11'b111_0001_0010;

  typedef enum logic {RATE_ONE = 1'b0, RATE_TWO = 1'b1} rate_e;

  typedef struct packed {
    logic                  frameLoad;
    logic                  bitTake;
    logic                  symEnd;
    logic                  chipOn;
    logic [CHIP_IDX_W-1:0] chipIdx;
  } strobe_t;
endpackage

// File: rtl/dsss_ctrl.sv
module dsss_ctrl
  import dsss_pkg::*;
#(
  parameter int CHIPS = BARKER_LEN
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStart,
  input  logic    rateSel,
  input  logic    bitValid,
  output logic    bitReady,
  output strobe_t strobe
);
  localparam logic [CHIP_IDX_W-1:0] LAST_IDX = CHIP_IDX_W'(CHIPS - 1);

  logic                  busy;
  logic                  havePrev;
  logic [CHIP_IDX_W-1:0] chipIdx;
  logic                  bitTake;
  logic                  symEnd;

  assign bitReady = !busy && !frameStart;
  assign bitTake  = bitValid && bitReady;
  assign symEnd   = bitTake && ((rate_e'(rateSel) == RATE_ONE) || havePrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      havePrev <= 1'b0;
      chipIdx  <= '0;
    end else if (frameStart) begin
      busy     <= 1'b0;
      havePrev <= 1'b0;
      chipIdx  <= '0;
    end else if (symEnd) begin
      busy     <= 1'b1;
      havePrev <= 1'b0;
      chipIdx  <= '0;
    end else if (bitTake) begin
      havePrev <= 1'b1;
    end else if (busy) begin
      if (chipIdx == LAST_IDX) begin
        busy    <= 1'b0;
        chipIdx <= '0;
      end else begin
        chipIdx <= chipIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.frameLoad = frameStart;
    strobe.bitTake   = bitTake;
    strobe.symEnd    = symEnd;
    strobe.chipOn    = busy;
    strobe.chipIdx   = chipIdx;
  end

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (chipIdx <= LAST_IDX));
  // R8
  sym_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    symEnd |=> (busy && chipIdx == '0));
  // R9
  sym_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && chipIdx == LAST_IDX) |=> (!busy && bitReady == !frameStart));
  // R10
  half_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTake && !symEnd) |=> !busy);
endmodule

// File: rtl/dsss_dp.sv
module dsss_dp
  import dsss_pkg::*;
#(
  parameter int SCR_LEN = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic               bitData,
  input  logic               rateSel,
  input  logic               rotReverse,
  input  logic               preambleShort,
  input  logic [SCR_LEN-1:0] seedLong,
  input  logic [SCR_LEN-1:0] seedShort,
  input  logic [SCR_LEN-1:0] tapMask,
  output logic               chipValid,
  output logic               chipI,
  output logic               chipQ
);
  logic [SCR_LEN-1:0] scrState;
  logic               scrBit;
  logic               firstBit;
  logic [1:0]         phaseQ;
  logic [1:0]         stepRaw;
  logic [1:0]         step;
  logic               symI;
  logic               symQ;
  logic               chipInv;

  assign scrBit = bitData ^ (^(scrState & tapMask));

  always_comb begin
    if (rate_e'(rateSel) == RATE_ONE) begin
      stepRaw = {scrBit, 1'b0};
    end else begin
      unique case ({firstBit, scrBit})
        2'b00:   stepRaw = 2'd0;
        2'b01:   stepRaw = 2'd1;
        2'b11:   stepRaw = 2'd2;
        default: stepRaw = 2'd3;
      endcase
    end
    step = rotReverse ? (~stepRaw + 2'd1) : stepRaw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrState <= '0;
      firstBit <= 1'b0;
      phaseQ   <= 2'd0;
    end else if (strobe.frameLoad) begin
      scrState <= preambleShort ? seedShort : seedLong;
      firstBit <= 1'b0;
      phaseQ   <= 2'd0;
    end else if (strobe.bitTake) begin
      scrState <= {scrState[SCR_LEN-2:0], scrBit};
      if (strobe.symEnd) phaseQ   <= phaseQ + step;
      else               firstBit <= scrBit;
    end
  end

  assign symI    = phaseQ[1] ^ phaseQ[0];
  assign symQ    = phaseQ[1];
  assign chipInv = BARKER_INV[strobe.chipIdx];

  assign chipValid = strobe.chipOn;
  assign chipI     = symI ^ chipInv;
  assign chipQ     = symQ ^ chipInv;

  // R3
  frame_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameLoad |=> (phaseQ == 2'd0 && !chipValid));
  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && $past(chipValid)) |-> $stable(phaseQ));
  // R4
  bpsk_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && rate_e'(rateSel) == RATE_ONE) |-> (chipI == chipQ));
endmodule

// File: rtl/dsss_barker_mod.sv
module dsss_barker_mod
  import dsss_pkg::*;
#(
  parameter int SCR_LEN = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               preambleShort,
  input  logic [SCR_LEN-1:0] seedLong,
  input  logic [SCR_LEN-1:0] seedShort,
  input  logic [SCR_LEN-1:0] tapMask,
  input  logic               rateSel,
  input  logic               rotReverse,
  input  logic               bitValid,
  input  logic               bitData,
  output logic               bitReady,
  output logic               chipValid,
  output logic               chipI,
  output logic               chipQ
);
  strobe_t strobe;

  dsss_ctrl #(.CHIPS(BARKER_LEN)) ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .rateSel(rateSel),
    .bitValid(bitValid), .bitReady(bitReady), .strobe(strobe)
  );

  dsss_dp #(.SCR_LEN(SCR_LEN)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitData(bitData),
    .rateSel(rateSel), .rotReverse(rotReverse), .preambleShort(preambleShort),
    .seedLong(seedLong), .seedShort(seedShort), .tapMask(tapMask),
    .chipValid(chipValid), .chipI(chipI), .chipQ(chipQ)
  );
endmodule

// File: tb/tb_dsss_barker_mod.sv
module tb_dsss_barker_mod;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, preambleShort = 1'b0, rateSel = 1'b0, rotReverse = 1'b0;
  logic [6:0] seedLong = '0, seedShort = '0, tapMask = 7'b1001000;
  logic bitValid = 1'b0, bitData = 1'b0;
  logic bitReady, chipValid, chipI, chipQ;

  int checks = 0, fails = 0;
  logic [6:0] mState = '0;
  logic [1:0] mPhase = '0;
  bit mHave = 0, mFirst = 0;

  always #2 clk = ~clk;

  dsss_barker_mod dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .preambleShort(preambleShort),
    .seedLong(seedLong), .seedShort(seedShort), .tapMask(tapMask), .rateSel(rateSel),
    .rotReverse(rotReverse), .bitValid(bitValid), .bitData(bitData),
    .bitReady(bitReady), .chipValid(chipValid), .chipI(chipI), .chipQ(chipQ)
  );

  function automatic bit negChip(int k);
    return (k == 1 || k == 4 || k == 8 || k == 9 || k == 10);
  endfunction

  function automatic logic [1:0] iqOf(logic [1:0] ph);
    case (ph)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic startFrame(bit rate, bit shortP, bit rev, logic [6:0] taps,
                            logic [6:0] sL, logic [6:0] sS);
    @(negedge clk);
    rateSel = rate; preambleShort = shortP; rotReverse = rev; tapMask = taps;
    seedLong = sL; seedShort = sS; frameStart = 1'b1;
    bitValid = 1'b1; bitData = 1'($urandom);
    #0;
    check(bitReady == 1'b0, "R3 ready during frame start", bitReady, 0);
    @(negedge clk);
    frameStart = 1'b0; bitValid = 1'b0;
    mState = shortP ? sS : sL; mPhase = 2'd0; mHave = 0;
  endtask

  task automatic sendBit(bit d, int abortAt);
    bit s, done;
    logic [1:0] st, iq;
    @(negedge clk);
    while (!bitReady) @(negedge clk);
    bitValid = 1'b1; bitData = d;
    s = d ^ (^(mState & tapMask));
    mState = {mState[5:0], s};
    done = 0;
    if (!rateSel) begin
      mPhase = mPhase + (s ? 2'd2 : 2'd0); done = 1;
    end else if (!mHave) begin
      mHave = 1; mFirst = s;
    end else begin
      case ({mFirst, s})
        2'b00: st = 2'd0;
        2'b01: st = 2'd1;
        2'b11: st = 2'd2;
        default: st = 2'd3;
      endcase
      if (rotReverse) st = 2'(4 - int'(st));
      mPhase = mPhase + st; mHave = 0; done = 1;
    end
    @(negedge clk);
    bitValid = 1'b0;
    if (!done) begin
      check(chipValid == 1'b0, "R10 no chips after first bit of pair", chipValid, 0);
      return;
    end
    iq = iqOf(mPhase);
    for (int k = 0; k < 11; k++) begin
      if (k > 0) @(negedge clk);
      check(chipValid && !bitReady, "R9 chip valid and ready low",
            {chipValid, bitReady}, 2'b10);
      check({chipI, chipQ} == (iq ^ {2{negChip(k)}}),
            rateSel ? "R5 R6 R7 R8 pair-mode chip" : "R4 R7 R8 one-bit chip",
            {chipI, chipQ}, iq ^ {2{negChip(k)}});
      if (abortAt == k) begin
        frameStart = 1'b1;
        @(negedge clk);
        frameStart = 1'b0;
        mState = preambleShort ? seedShort : seedLong; mPhase = 2'd0; mHave = 0;
        check(chipValid == 1'b0, "R3 frame start ends symbol", chipValid, 0);
        return;
      end
    end
    @(negedge clk);
    check(!chipValid && bitReady, "R9 ready after last chip", {chipValid, bitReady}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(chipValid == 1'b0 && bitReady == 1'b1, "R1 reset state",
          {chipValid, bitReady}, 2'b01);

    // R4 R2: taps off, data passes unscrambled
    startFrame(0, 0, 0, 7'h00, 7'h00, 7'h00);
    sendBit(0, -1); sendBit(1, -1); sendBit(1, -1); sendBit(0, -1);
    // R2 R3: default taps, short seed chosen
    startFrame(0, 1, 0, 7'b1001000, 7'h00, 7'h5B);
    for (int i = 0; i < 8; i++) sendBit(1'(i), -1);
    // R5: each pair pattern, no scrambling
    startFrame(1, 0, 0, 7'h00, 7'h00, 7'h00);
    sendBit(0, -1); sendBit(1, -1); sendBit(1, -1); sendBit(1, -1);
    sendBit(1, -1); sendBit(0, -1); sendBit(0, -1); sendBit(0, -1);
    // R6: reversed rotation
    startFrame(1, 0, 1, 7'h00, 7'h00, 7'h00);
    sendBit(0, -1); sendBit(1, -1); sendBit(0, -1); sendBit(1, -1);
    sendBit(1, -1); sendBit(0, -1);
    // R3: odd bit left, then new frame drops it
    startFrame(1, 0, 0, 7'b1001000, 7'h2A, 7'h11);
    sendBit(1, -1);
    startFrame(1, 0, 0, 7'b1001000, 7'h2A, 7'h11);
    sendBit(0, -1); sendBit(1, -1);
    // R3: frame start during chips
    startFrame(0, 0, 0, 7'b1001000, 7'h33, 7'h44);
    sendBit(1, 3);
    sendBit(1, -1);

    // random frames
    for (int f = 0; f < 40; f++) begin
      bit r;
      int n;
      r = 1'($urandom);
      startFrame(r, 1'($urandom), 1'($urandom),
                 ($urandom % 3 == 0) ? 7'b1001000 : 7'($urandom),
                 7'($urandom), 7'($urandom));
      n = 4 + int'($urandom % 14);
      for (int b = 0; b < n; b++) sendBit(1'($urandom), -1);
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule